// File: doc/BRIEF.md
# Guest Control Register High-Half Writer

This block carries out one instruction: a move of a general-register value into the upper 32 bits of a 64-bit guest system-control register. It decodes the instruction word and picks the target entry from the register number and select fields. It then commits the write into a small parameterised file of guest registers, all on one clock edge. The caller supplies the instruction word, the source value already read from the general register file, an access-enable flag for the control registers, the large-physical-address flags and the configured physical-address width.

Each entry in the file has a kind set by parameter. A replicated entry takes the whole source value into its upper half. A shared entry changes only the bits its guest-visible mask allows. A reserved entry, or a register number and select pair that matches no entry, ignores the write. The two translation-entry-low registers remap the source: the two low source bits go to bits 31:30, and the remaining 30 bits fill bits 61:32 through an address-width mask. The inhibit bits 63:62 are never touched.

A malformed word raises a one-cycle reserved-instruction pulse. A well-formed word issued while control-register access is off raises a one-cycle coprocessor-unusable pulse. Neither case writes anything. No guest-specific trap is ever produced.

Top module: `gcr_hiwrite`

## Requirements
- R1: A word is legal only when bits 31:26 are 000000, bits 15:14 are 00, bits 10:6 are 11011 and bits 5:0 are 110100. The register number is bits 20:16, the select is bits 13:11 and bits 25:21 are not used. A valid illegal word sets ri_exc high in the cycle after it is accepted, and no register changes.
- R2: A valid legal word with cp_access_en low sets cu_exc high in the next cycle, and no register changes.
- R3: When a valid word is illegal and cp_access_en is also low, only ri_exc is raised.
- R4: A write to a replicated entry loads src_data into bits 63:32 on the accepting edge and leaves bits 31:0 unchanged.
- R5: A write to a shared entry changes only the bits of 63:32 set in that entry's visibility mask; all other bits keep their value.
- R6: A write to a reserved entry, or to a number/select pair that matches no entry, leaves every register unchanged and raises no exception.
- R7: For a translation-entry-low entry with lpa_supported and lpa_enabled both high, one edge loads bits 31:30 with src_data[1:0] and bits 61:32 with src_data[31:2] AND mask. The mask is 2^(pa_width-36)-1: zero when pa_width is 36 or less, and all 30 bits set when pa_width is 66 or more. Bits 63:62 and 29:0 are unchanged.
- R8: For a translation-entry-low entry when large physical addressing is not both supported and enabled, bits 61:32 are cleared and bits 63:62 and 31:0 are unchanged.
- R9: cu_exc and ri_exc are never high together. Each is high only in the cycle after a matching accepted word. With instr_valid low, nothing is written and neither is raised.
- R10: After reset every register bit is zero and both exception outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| src_data | input | 32 | Value of the source general register |
| cp_access_en | input | 1 | Control-register access permitted |
| lpa_supported | input | 1 | Large physical addressing implemented |
| lpa_enabled | input | 1 | Large physical addressing switched on |
| pa_width | input | 7 | Configured physical-address width in bits |
| regs_flat | output | NREG*64 | Register file contents, entry i at bits [64*i +: 64] |
| cu_exc | output | 1 | Coprocessor-unusable pulse |
| ri_exc | output | 1 | Reserved-instruction pulse |

## Verification
Two things meet on one edge in a translation-entry-low write: the bits 31:30 update and the upper-field update. The bench sends source values whose low two bits and high bits differ. It checks both fields in the first sample after that edge, so a split or late half shows up as a mismatch. A second overlap is an exception pulse ending in the same cycle that the next instruction's write lands. Back-to-back words (reserved, then a write, then access-disabled) check that each pulse lasts exactly one cycle and that the write beside it is neither lost nor blocked.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  localparam int PAW = 7;

  typedef enum logic [1:0] {
    KIND_RSVD   = 2'd0,
    KIND_REPL   = 2'd1,
    KIND_SHARED = 2'd2,
    KIND_TLO    = 2'd3
  } gcr_kind_e;

  localparam logic [5:0] MAJOR_OP = 6'b000000;
  localparam logic [4:0] MINOR_OP = 5'b11011;
  localparam logic [5:0] TRAIL_OP = 6'b110100;

  typedef struct packed {
    logic [5:0] major;
    logic [4:0] rt;
    logic [4:0] rs;
    logic [1:0] zpad;
    logic [2:0] sel;
    logic [4:0] minor;
    logic [5:0] trail;
  } hiw_word_t;

  // Mask applied to the 30 shifted source bits, from the address width.
  function automatic logic [29:0] pa_mask(input logic [PAW-1:0] pa_w);
    logic [PAW-1:0] extra;
    if (pa_w <= PAW'(36)) return '0;
    extra = pa_w - PAW'(36);
    if (extra >= PAW'(30)) return '1;
    return (30'd1 << extra) - 30'd1;
  endfunction

  function automatic logic [63:0] tlo_merge(input logic [63:0] old_v,
                                            input logic [31:0] src,
                                            input logic        lpa_on,
                                            input logic [29:0] mask);
    logic [63:0] r;
    r = old_v;
    if (lpa_on) begin
      r[31:30] = src[1:0];
      r[61:32] = src[31:2] & mask;
    end else begin
      r[61:32] = '0;
    end
    return r;
  endfunction

  function automatic logic [63:0] shared_merge(input logic [63:0] old_v,
                                               input logic [31:0] src,
                                               input logic [31:0] vis);
    logic [63:0] r;
    r = old_v;
    r[63:32] = (old_v[63:32] & ~vis) | (src & vis);
    return r;
  endfunction

  function automatic logic [63:0] repl_merge(input logic [63:0] old_v,
                                             input logic [31:0] src);
    logic [63:0] r;
    r = old_v;
    r[63:32] = src;
    return r;
  endfunction

endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
(
  input  logic        instr_valid,
  input  logic [31:0] instr,
  input  logic        cp_access_en,
  output logic [4:0]  rs,
  output logic [2:0]  sel,
  output logic        wr_fire,
  output logic        cu_fire,
  output logic        ri_fire
);
  hiw_word_t w;
  logic      legal;
  logic      unused_rt;

  assign w         = hiw_word_t'(instr);
  assign rs        = w.rs;
  assign sel       = w.sel;
  assign unused_rt = ^w.rt;

  assign legal = (w.major == MAJOR_OP) && (w.zpad == 2'b00) &&
                 (w.minor == MINOR_OP) && (w.trail == TRAIL_OP);

  // Malformed words win over the access check.
  assign ri_fire = instr_valid && !legal;
  assign cu_fire = instr_valid && legal && !cp_access_en;
  assign wr_fire = instr_valid && legal && cp_access_en;
endmodule

// File: rtl/gcr_target_match.sv
module gcr_target_match #(
  parameter int                  NREG       = 5,
  parameter logic [NREG*8-1:0]   ENTRY_ADDR = '0
) (
  input  logic [4:0]      rs,
  input  logic [2:0]      sel,
  input  logic            wr_fire,
  output logic [NREG-1:0] hit_vec
);
  logic [7:0] key;
  assign key = {rs, sel};

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign hit_vec[i] = wr_fire && (key == ENTRY_ADDR[8*i +: 8]);
  end
endmodule

// File: rtl/gcr_entry.sv
module gcr_entry
  import gcr_pkg::*;
#(
  parameter gcr_kind_e   KIND = KIND_REPL,
  parameter logic [31:0] VIS  = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] src,
  input  logic        lpa_on,
  input  logic [29:0] mask,
  output logic [63:0] q
);
  logic [63:0] nxt;

  if (KIND == KIND_RSVD) begin : g_rsvd
    logic unused_in;
    assign unused_in = ^{wr_en, src, lpa_on, mask};
    assign nxt = '0;
  end else if (KIND == KIND_TLO) begin : g_tlo
    assign nxt = tlo_merge(q, src, lpa_on, mask);
  end else if (KIND == KIND_SHARED) begin : g_shared
    logic unused_in;
    assign unused_in = ^{lpa_on, mask};
    assign nxt = shared_merge(q, src, VIS);
  end else begin : g_repl
    logic unused_in;
    assign unused_in = ^{lpa_on, mask};
    assign nxt = repl_merge(q, src);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr_en && (KIND != KIND_RSVD)) q <= nxt;
  end
endmodule

// File: rtl/gcr_hiwrite.sv
module gcr_hiwrite
  import gcr_pkg::*;
#(
  parameter int                 NREG        = 5,
  parameter logic [NREG*8-1:0]  ENTRY_ADDR  = {8'h4A, 8'h99, 8'h88, 8'h18, 8'h10},
  parameter logic [NREG*2-1:0]  ENTRY_KIND  = {2'd0, 2'd2, 2'd1, 2'd3, 2'd3},
  parameter logic [NREG*32-1:0] SHARED_MASK = {32'h0, 32'h00FF_0F0F, 32'hFFFF_FFFF, 32'h0, 32'h0}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [31:0]          instr,
  input  logic [31:0]          src_data,
  input  logic                 cp_access_en,
  input  logic                 lpa_supported,
  input  logic                 lpa_enabled,
  input  logic [PAW-1:0]       pa_width,
  output logic [NREG*64-1:0]   regs_flat,
  output logic                 cu_exc,
  output logic                 ri_exc
);
  logic [4:0]      dec_rs;
  logic [2:0]      dec_sel;
  logic            wr_fire;
  logic            cu_fire;
  logic            ri_fire;
  logic [NREG-1:0] hit_vec;
  logic            lpa_on;
  logic [29:0]     lpa_mask_v;

  assign lpa_on     = lpa_supported && lpa_enabled;
  assign lpa_mask_v = pa_mask(pa_width);

  gcr_decode u_dec (
    .instr_valid  (instr_valid),
    .instr        (instr),
    .cp_access_en (cp_access_en),
    .rs           (dec_rs),
    .sel          (dec_sel),
    .wr_fire      (wr_fire),
    .cu_fire      (cu_fire),
    .ri_fire      (ri_fire)
  );

  gcr_target_match #(.NREG(NREG), .ENTRY_ADDR(ENTRY_ADDR)) u_match (
    .rs      (dec_rs),
    .sel     (dec_sel),
    .wr_fire (wr_fire),
    .hit_vec (hit_vec)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    gcr_entry #(
      .KIND (gcr_kind_e'(ENTRY_KIND[2*i +: 2])),
      .VIS  (SHARED_MASK[32*i +: 32])
    ) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (hit_vec[i]),
      .src    (src_data),
      .lpa_on (lpa_on),
      .mask   (lpa_mask_v),
      .q      (regs_flat[64*i +: 64])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cu_exc <= 1'b0;
      ri_exc <= 1'b0;
    end else begin
      cu_exc <= cu_fire;
      ri_exc <= ri_fire;
    end
  end
endmodule

// File: rtl/gcr_hiwrite_chk.sv
module gcr_hiwrite_chk #(
  parameter int                 NREG        = 5,
  parameter logic [NREG*2-1:0]  ENTRY_KIND  = '0,
  parameter logic [NREG*32-1:0] SHARED_MASK = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NREG*64-1:0]  regs_flat,
  input logic                cu_exc,
  input logic                ri_exc,
  input logic                cu_fire,
  input logic                ri_fire,
  input logic [NREG-1:0]     hit_vec
);
  // R9
  exc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cu_exc, ri_exc}));

  // R3
  ri_over_cu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ri_fire |-> !cu_fire);

  // R2
  cu_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cu_exc |-> regs_flat == $past(regs_flat));

  // R1
  ri_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ri_exc |-> regs_flat == $past(regs_flat));

  // R9
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (ENTRY_KIND[2*i +: 2] == 2'd0) begin : g_rsvd
      // R6
      rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_flat[64*i +: 64] == 64'd0);
    end else if (ENTRY_KIND[2*i +: 2] == 2'd2) begin : g_sh
      // R5
      shared_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_flat[64*i+32 +: 32] & ~SHARED_MASK[32*i +: 32]) ==
        ($past(regs_flat[64*i+32 +: 32]) & ~SHARED_MASK[32*i +: 32]));
    end else if (ENTRY_KIND[2*i +: 2] == 2'd3) begin : g_tlo
      // R7
      tlo_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(regs_flat[64*i+62 +: 2]));
      // R8
      tlo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(regs_flat[64*i +: 30]));
    end
  end
endmodule

bind gcr_hiwrite gcr_hiwrite_chk #(
  .NREG        (NREG),
  .ENTRY_KIND  (ENTRY_KIND),
  .SHARED_MASK (SHARED_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regs_flat (regs_flat),
  .cu_exc    (cu_exc),
  .ri_exc    (ri_exc),
  .cu_fire   (cu_fire),
  .ri_fire   (ri_fire),
  .hit_vec   (hit_vec)
);

// File: tb/gcr_hiwrite_bench.sv
module gcr_hiwrite_bench;
  localparam int NREG = 5;
  localparam logic [31:0] SH_VIS = 32'h00FF_0F0F;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                instr_valid = 1'b0;
  logic [31:0]         instr = '0;
  logic [31:0]         src_data = '0;
  logic                cp_access_en = 1'b0;
  logic                lpa_supported = 1'b0;
  logic                lpa_enabled = 1'b0;
  logic [6:0]          pa_width = 7'd36;
  logic [NREG*64-1:0]  regs_flat;
  logic                cu_exc;
  logic                ri_exc;

  always #10 clk = ~clk;

  gcr_hiwrite u_gcr_hiwrite (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr         (instr),
    .src_data      (src_data),
    .cp_access_en  (cp_access_en),
    .lpa_supported (lpa_supported),
    .lpa_enabled   (lpa_enabled),
    .pa_width      (pa_width),
    .regs_flat     (regs_flat),
    .cu_exc        (cu_exc),
    .ri_exc        (ri_exc)
  );

  typedef struct {
    logic [NREG*64-1:0] regs;
    logic               cu;
    logic               ri;
    string              tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] m_regs [NREG];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  function automatic logic [31:0] mkword(input logic [4:0] rs, input logic [2:0] sel);
    return {6'b000000, 5'd7, rs, 2'b00, sel, 5'b11011, 6'b110100};
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] s,
                      input logic en, input logic sup, input logic ena,
                      input logic [6:0] pw, input string tag);
    exp_t        e;
    bit          legal;
    logic [7:0]  key;
    logic [63:0] nv;
    @(negedge clk);
    instr_valid = v; instr = w; src_data = s; cp_access_en = en;
    lpa_supported = sup; lpa_enabled = ena; pa_width = pw;
    legal = (w[31:26] == 6'd0) && (w[15:14] == 2'd0) &&
            (w[10:6] == 5'b11011) && (w[5:0] == 6'b110100);
    key = {w[20:16], w[13:11]};
    e.cu = v && legal && !en;
    e.ri = v && !legal;
    e.tag = tag;
    if (v && legal && en) begin
      if (key == 8'h10 || key == 8'h18) begin
        int idx = (key == 8'h10) ? 0 : 1;
        nv = m_regs[idx];
        if (sup && ena) begin
          nv[31:30] = s[1:0];
          for (int b = 0; b < 30; b++) nv[32+b] = s[2+b] & ((int'(pw) - 36) > b);
        end else begin
          for (int b = 32; b < 62; b++) nv[b] = 1'b0;
        end
        m_regs[idx] = nv;
      end else if (key == 8'h88) begin
        m_regs[2][63:32] = s;
      end else if (key == 8'h99) begin
        for (int b = 0; b < 32; b++)
          if (SH_VIS[b]) m_regs[3][32+b] = s[b];
      end
    end
    for (int i = 0; i < NREG; i++) e.regs[64*i +: 64] = m_regs[i];
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, mkword(5'd17, 3'd0), 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, 7'd48, tag);
  endtask

  always begin
    @(posedge clk);
    #5;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (regs_flat !== e.regs || cu_exc !== e.cu || ri_exc !== e.ri) begin
        n_bad++;
        $display("FAIL %s: regs=%h cu=%b ri=%b expected regs=%h cu=%b ri=%b",
                 e.tag, regs_flat, cu_exc, ri_exc, e.regs, e.cu, e.ri);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R10 reset state");
    // replicated entry
    step(1, mkword(5'd17, 3'd0), 32'h1234_5678, 1, 0, 0, 7'd36, "R4 replicated write");
    step(1, mkword(5'd17, 3'd0), 32'hA5A5_0F0F, 1, 1, 1, 7'd40, "R4 replicated overwrite");
    // shared entry
    step(1, mkword(5'd19, 3'd1), 32'hFFFF_FFFF, 1, 0, 0, 7'd36, "R5 shared all ones");
    step(1, mkword(5'd19, 3'd1), 32'h1234_5670, 1, 0, 0, 7'd36, "R5 shared partial");
    // reserved and unmatched
    step(1, mkword(5'd9, 3'd2), 32'hFFFF_FFFF, 1, 1, 1, 7'd48, "R6 reserved entry");
    step(1, mkword(5'd17, 3'd5), 32'hFFFF_FFFF, 1, 1, 1, 7'd48, "R6 unmatched select");
    // translation-entry-low with large addressing on
    step(1, mkword(5'd2, 3'd0), 32'hFFFF_FFFE, 1, 1, 1, 7'd40, "R7 lo0 width 40");
    step(1, mkword(5'd3, 3'd0), 32'hABCD_EF01, 1, 1, 1, 7'd48, "R7 lo1 width 48");
    step(1, mkword(5'd2, 3'd0), 32'hFFFF_FFFF, 1, 1, 1, 7'd36, "R7 lo0 width 36 zero mask");
    step(1, mkword(5'd3, 3'd0), 32'hFFFF_FFFF, 1, 1, 1, 7'd70, "R7 lo1 width 70 full mask");
    // translation-entry-low with large addressing off
    step(1, mkword(5'd3, 3'd0), 32'h5555_5556, 1, 1, 0, 7'd48, "R8 lo1 not enabled");
    step(1, mkword(5'd2, 3'd0), 32'hFFFF_FFFD, 1, 1, 1, 7'd60, "R7 lo0 refill");
    step(1, mkword(5'd2, 3'd0), 32'hFFFF_FFFF, 1, 0, 1, 7'd60, "R8 lo0 not supported");
    // malformed words
    step(1, mkword(5'd17, 3'd0) | 32'h0400_0000, 32'h1, 1, 0, 0, 7'd36, "R1 major opcode");
    step(1, mkword(5'd17, 3'd0) | 32'h0000_4000, 32'h2, 1, 0, 0, 7'd36, "R1 zero field");
    step(1, mkword(5'd17, 3'd0) ^ 32'h0000_0040, 32'h3, 1, 0, 0, 7'd36, "R1 minor opcode");
    step(1, mkword(5'd17, 3'd0) ^ 32'h0000_0001, 32'h4, 1, 0, 0, 7'd36, "R1 trailing opcode");
    idle("R9 pulse ends");
    // access disabled
    step(1, mkword(5'd17, 3'd0), 32'h0BAD_0BAD, 0, 0, 0, 7'd36, "R2 access disabled");
    step(1, mkword(5'd19, 3'd1) | 32'h0000_8000, 32'h7, 0, 0, 0, 7'd36, "R3 illegal and disabled");
    // back to back: reserved, write, disabled, idle
    step(1, mkword(5'd2, 3'd0) ^ 32'h0000_0002, 32'h9, 1, 1, 1, 7'd48, "R9 b2b reserved");
    step(1, mkword(5'd2, 3'd0), 32'h8765_4323, 1, 1, 1, 7'd50, "R9 b2b write after pulse");
    step(1, mkword(5'd19, 3'd1), 32'h0, 0, 1, 1, 7'd50, "R9 b2b disabled");
    step(1, mkword(5'd19, 3'd1), 32'h0000_F0F0, 1, 1, 1, 7'd50, "R5 b2b shared after cu");
    idle("R9 idle after burst");
    idle("R9 valid low no write");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule